// File: doc/BRIEF.md
# L2 Slice Flush Handler

This block handles write-flush requests that arrive at one slice of a shared second-level cache. Each request names a cache line and carries the requesting L1 client's ID and the sequence number of the instruction that issued it. The handler keeps a per-line state table with a data block and an accumulated byte write mask for each line. The rest of the slice controller writes that table through an update port. When a flush arrives, the line's state decides what happens. A transient or atomic-pending line holds the flush in a small stall queue. An invalid line sends an acknowledgement straight back to the requestor. A valid or written line sends its data and mask to the directory and is then invalidated.

Outbound traffic uses two valid/ready channels: an acknowledgement channel toward the L1 clients and a request channel toward the directory. The handler consumes an incoming flush only in the cycle its message is accepted, or in the cycle it enters the stall queue. Queued flushes are replayed in arrival order once the line at the head of the queue reaches a stable state. A replay takes priority over new input.

Top module: `l2fl_flush_top`

## Requirements
- R1: After reset every line is invalid, the stall queue is empty and neither outbound channel is valid, so a first flush to any line is acknowledged.
- R2: Line states are encoded invalid=0, valid=1, written=2, atomic-pending=3, invalid-to-valid=4, write-in-progress=5, write-awaiting-ack=6. The update port writes state, data and mask of one line. A flush to a line in state 3, 4, 5 or 6 (or the unused code 7) enters the stall queue, raises req_ready when the queue has room, and produces no outbound message.
- R3: A flush to an invalid line raises ack_valid with ack_dst equal to the requestor ID and ack_seq equal to its sequence number. No directory message is sent, and the line stays invalid.
- R4: A flush to a valid or written line raises dir_valid. The message carries the line index, the line's data and byte mask, dir_dirty=1, and the original requestor ID and sequence number.
- R5: In the cycle a directory message is accepted, the line becomes invalid and its mask is cleared, so a later flush to it is acknowledged.
- R6: At most one outbound channel is valid in a cycle. A flush that issues a message is consumed (req_ready high) only in a cycle where that channel's ready is high.
- R7: When the queue is non-empty and its head's line is in state 0, 1 or 2, the head is replayed in arrival order under R3/R4 rules. In that cycle req_ready is low.
- R8: A new flush to a line that matches any queued entry is queued behind it, even if the line is stable.
- R9: With the queue full, a flush bound for the queue sees req_ready low and is not taken.
- R10: If an update and an accepted directory message hit the same line in one cycle, the line ends invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Line table write from the slice controller |
| upd_line | input | LINE_W | Line written |
| upd_state | input | 3 | New state code (R2 encoding) |
| upd_data | input | DATA_W | New line data |
| upd_mask | input | DATA_W/8 | New byte write mask |
| req_valid | input | 1 | Flush request present |
| req_ready | output | 1 | Flush request consumed |
| req_line | input | LINE_W | Line to flush |
| req_src | input | ID_W | Requestor ID |
| req_seq | input | SEQ_W | Instruction sequence number |
| ack_valid | output | 1 | Acknowledgement to an L1 valid |
| ack_ready | input | 1 | Acknowledgement accepted |
| ack_dst | output | ID_W | Destination requestor |
| ack_seq | output | SEQ_W | Echoed sequence number |
| dir_valid | output | 1 | Directory write-flush valid |
| dir_ready | input | 1 | Directory message accepted |
| dir_line | output | LINE_W | Line index |
| dir_src | output | ID_W | Original requestor |
| dir_seq | output | SEQ_W | Original sequence number |
| dir_data | output | DATA_W | Line data |
| dir_mask | output | DATA_W/8 | Byte write mask |
| dir_dirty | output | 1 | Dirty flag, set on every directory message |

## Verification
A corrupted line state shows at the ports in the next flush to that line. It appears as the wrong channel (ack instead of directory message, or the reverse), or as a request that is queued when it should have been served. A queue ordering or occupancy fault shows as a replay carrying the wrong requestor or sequence number, or as req_ready disagreeing with the queue's fill level. The bench's reference model compares every channel and field in every cycle. Any divergence is therefore reported in the first cycle that a flush touches the affected line or queue slot.

// File: rtl/l2fl_pkg.sv
package l2fl_pkg;

   typedef enum logic [2:0] {
      LS_INV     = 3'd0,
      LS_VALID   = 3'd1,
      LS_WRITTEN = 3'd2,
      LS_ATOMIC  = 3'd3,
      LS_FILL    = 3'd4,
      LS_WRPROG  = 3'd5,
      LS_WRWAIT  = 3'd6,
      LS_RSVD    = 3'd7
   } line_state_e;

   // a flush must wait unless the line is in one of the stable states
   function automatic logic holds_flush(line_state_e s);
      return !(s == LS_INV || s == LS_VALID || s == LS_WRITTEN);
   endfunction

endpackage

// File: rtl/l2fl_line_table.sv
module l2fl_line_table
   import l2fl_pkg::*;
#(
   parameter int LINES  = 8,
   parameter int DATA_W = 64,
   localparam int LINE_W = $clog2(LINES),
   localparam int MASK_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [LINE_W-1:0] upd_idx,
   input  line_state_e       upd_state,
   input  logic [DATA_W-1:0] upd_data,
   input  logic [MASK_W-1:0] upd_mask,
   input  logic              inv_en,
   input  logic [LINE_W-1:0] inv_idx,
   input  logic [LINE_W-1:0] rd_idx_a,
   output line_state_e       rd_state_a,
   output logic [DATA_W-1:0] rd_data_a,
   output logic [MASK_W-1:0] rd_mask_a,
   input  logic [LINE_W-1:0] rd_idx_b,
   output line_state_e       rd_state_b,
   output logic [DATA_W-1:0] rd_data_b,
   output logic [MASK_W-1:0] rd_mask_b
);

   initial begin
      assert (LINES >= 2 && (1 << LINE_W) == LINES)
         else $error("LINES must be a power of two, at least 2");
      assert (DATA_W >= 8 && DATA_W % 8 == 0)
         else $error("DATA_W must be a whole number of bytes");
   end

   line_state_e       st_arr   [LINES];
   logic [DATA_W-1:0] data_arr [LINES];
   logic [MASK_W-1:0] mask_arr [LINES];

   for (genvar g = 0; g < LINES; g++) begin : g_line
      line_state_e       st_r;
      logic [DATA_W-1:0] data_r;
      logic [MASK_W-1:0] mask_r;
      logic              hit_inv, hit_upd;

      assign hit_inv = inv_en && (inv_idx == LINE_W'(g));
      assign hit_upd = upd_en && (upd_idx == LINE_W'(g));

      // flush invalidation outranks a same-cycle update (R10)
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r   <= LS_INV;
            data_r <= '0;
            mask_r <= '0;
         end else if (hit_inv) begin
            st_r   <= LS_INV;
            mask_r <= '0;
         end else if (hit_upd) begin
            st_r   <= upd_state;
            data_r <= upd_data;
            mask_r <= upd_mask;
         end
      end

      assign st_arr[g]   = st_r;
      assign data_arr[g] = data_r;
      assign mask_arr[g] = mask_r;
   end

   assign rd_state_a = st_arr[rd_idx_a];
   assign rd_data_a  = data_arr[rd_idx_a];
   assign rd_mask_a  = mask_arr[rd_idx_a];
   assign rd_state_b = st_arr[rd_idx_b];
   assign rd_data_b  = data_arr[rd_idx_b];
   assign rd_mask_b  = mask_arr[rd_idx_b];

   assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      inv_en |=> (st_arr[$past(inv_idx)] == LS_INV && mask_arr[$past(inv_idx)] == '0));

endmodule

// File: rtl/l2fl_stall_queue.sv
module l2fl_stall_queue #(
   parameter int DEPTH  = 4,
   parameter int LINE_W = 3,
   parameter int ID_W   = 4,
   parameter int SEQ_W  = 8,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [LINE_W-1:0] push_line,
   input  logic [ID_W-1:0]   push_id,
   input  logic [SEQ_W-1:0]  push_seq,
   input  logic              pop,
   input  logic [LINE_W-1:0] probe_line,
   output logic              probe_hit,
   output logic [LINE_W-1:0] head_line,
   output logic [ID_W-1:0]   head_id,
   output logic [SEQ_W-1:0]  head_seq,
   output logic              empty,
   output logic              full
);

   initial begin
      assert (DEPTH >= 2 && (1 << PTR_W) == DEPTH)
         else $error("DEPTH must be a power of two, at least 2");
   end

   logic [LINE_W-1:0] line_mem [DEPTH];
   logic [ID_W-1:0]   id_mem   [DEPTH];
   logic [SEQ_W-1:0]  seq_mem  [DEPTH];
   logic [DEPTH-1:0]  occ_q, occ_nxt, hits;
   logic [PTR_W-1:0]  wr_q, rd_q;

   always_comb begin
      occ_nxt = occ_q;
      if (pop)  occ_nxt[rd_q] = 1'b0;
      if (push) occ_nxt[wr_q] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         occ_q <= '0;
         wr_q  <= '0;
         rd_q  <= '0;
      end else begin
         occ_q <= occ_nxt;
         if (push) wr_q <= wr_q + 1'b1;
         if (pop)  rd_q <= rd_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         line_mem[wr_q] <= push_line;
         id_mem[wr_q]   <= push_id;
         seq_mem[wr_q]  <= push_seq;
      end
   end

   for (genvar i = 0; i < DEPTH; i++) begin : g_probe
      assign hits[i] = occ_q[i] && (line_mem[i] == probe_line);
   end

   assign probe_hit = |hits;
   assign head_line = line_mem[rd_q];
   assign head_id   = id_mem[rd_q];
   assign head_seq  = seq_mem[rd_q];
   assign empty     = (occ_q == '0);
   assign full      = &occ_q;

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);

   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);

endmodule

// File: rtl/l2fl_dispatch.sv
module l2fl_dispatch
   import l2fl_pkg::*;
#(
   parameter int LINE_W = 3,
   parameter int DATA_W = 64,
   parameter int ID_W   = 4,
   parameter int SEQ_W  = 8,
   localparam int MASK_W = DATA_W / 8
) (
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [LINE_W-1:0] req_line,
   input  logic [ID_W-1:0]   req_src,
   input  logic [SEQ_W-1:0]  req_seq,
   input  line_state_e       req_state,
   input  logic [DATA_W-1:0] req_data,
   input  logic [MASK_W-1:0] req_mask,
   input  logic              q_empty,
   input  logic              q_full,
   input  logic              q_hit,
   input  logic [LINE_W-1:0] head_line,
   input  logic [ID_W-1:0]   head_src,
   input  logic [SEQ_W-1:0]  head_seq,
   input  line_state_e       head_state,
   input  logic [DATA_W-1:0] head_data,
   input  logic [MASK_W-1:0] head_mask,
   output logic              q_push,
   output logic              q_pop,
   output logic              ack_valid,
   input  logic              ack_ready,
   output logic [ID_W-1:0]   ack_dst,
   output logic [SEQ_W-1:0]  ack_seq,
   output logic              dir_valid,
   input  logic              dir_ready,
   output logic [LINE_W-1:0] dir_line,
   output logic [ID_W-1:0]   dir_src,
   output logic [SEQ_W-1:0]  dir_seq,
   output logic [DATA_W-1:0] dir_data,
   output logic [MASK_W-1:0] dir_mask,
   output logic              inv_en,
   output logic [LINE_W-1:0] inv_idx
);

   logic              replay, issue, fire, to_queue;
   line_state_e       sel_state;
   logic [LINE_W-1:0] sel_line;
   logic [ID_W-1:0]   sel_src;
   logic [SEQ_W-1:0]  sel_seq;
   logic [DATA_W-1:0] sel_data;
   logic [MASK_W-1:0] sel_mask;

   assign replay   = !q_empty && !holds_flush(head_state);
   assign to_queue = !replay && req_valid && (holds_flush(req_state) || q_hit);
   assign issue    = replay || (req_valid && !to_queue);

   always_comb begin
      if (replay) begin
         sel_state = head_state;
         sel_line  = head_line;
         sel_src   = head_src;
         sel_seq   = head_seq;
         sel_data  = head_data;
         sel_mask  = head_mask;
      end else begin
         sel_state = req_state;
         sel_line  = req_line;
         sel_src   = req_src;
         sel_seq   = req_seq;
         sel_data  = req_data;
         sel_mask  = req_mask;
      end
   end

   assign ack_valid = issue && (sel_state == LS_INV);
   assign dir_valid = issue && (sel_state != LS_INV);
   assign fire      = (ack_valid && ack_ready) || (dir_valid && dir_ready);

   assign q_push    = to_queue && !q_full;
   assign q_pop     = replay && fire;
   assign req_ready = !replay && ((to_queue && !q_full) || (issue && fire));

   assign ack_dst   = sel_src;
   assign ack_seq   = sel_seq;
   assign dir_line  = sel_line;
   assign dir_src   = sel_src;
   assign dir_seq   = sel_seq;
   assign dir_data  = sel_data;
   assign dir_mask  = sel_mask;

   assign inv_en    = dir_valid && dir_ready;
   assign inv_idx   = sel_line;

endmodule

// File: rtl/l2fl_flush_top.sv
module l2fl_flush_top
   import l2fl_pkg::*;
#(
   parameter int LINES   = 8,
   parameter int DATA_W  = 64,
   parameter int ID_W    = 4,
   parameter int SEQ_W   = 8,
   parameter int Q_DEPTH = 4,
   localparam int LINE_W = $clog2(LINES),
   localparam int MASK_W = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd_en,
   input  logic [LINE_W-1:0] upd_line,
   input  logic [2:0]        upd_state,
   input  logic [DATA_W-1:0] upd_data,
   input  logic [MASK_W-1:0] upd_mask,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [LINE_W-1:0] req_line,
   input  logic [ID_W-1:0]   req_src,
   input  logic [SEQ_W-1:0]  req_seq,
   output logic              ack_valid,
   input  logic              ack_ready,
   output logic [ID_W-1:0]   ack_dst,
   output logic [SEQ_W-1:0]  ack_seq,
   output logic              dir_valid,
   input  logic              dir_ready,
   output logic [LINE_W-1:0] dir_line,
   output logic [ID_W-1:0]   dir_src,
   output logic [SEQ_W-1:0]  dir_seq,
   output logic [DATA_W-1:0] dir_data,
   output logic [MASK_W-1:0] dir_mask,
   output logic              dir_dirty
);

   initial begin
      assert (ID_W >= 1 && SEQ_W >= 1) else $error("ID_W and SEQ_W must be positive");
   end

   line_state_e       req_state, head_state;
   logic [DATA_W-1:0] req_data, head_data;
   logic [MASK_W-1:0] req_mask, head_mask;
   logic              q_push, q_pop, q_hit, q_empty, q_full;
   logic [LINE_W-1:0] head_line, inv_idx;
   logic [ID_W-1:0]   head_src;
   logic [SEQ_W-1:0]  head_seq;
   logic              inv_en;

   l2fl_line_table #(.LINES(LINES), .DATA_W(DATA_W)) table_i (
      .clk, .rst_n,
      .upd_en, .upd_idx(upd_line), .upd_state(line_state_e'(upd_state)),
      .upd_data, .upd_mask,
      .inv_en, .inv_idx,
      .rd_idx_a(req_line), .rd_state_a(req_state), .rd_data_a(req_data), .rd_mask_a(req_mask),
      .rd_idx_b(head_line), .rd_state_b(head_state), .rd_data_b(head_data), .rd_mask_b(head_mask)
   );

   l2fl_stall_queue #(.DEPTH(Q_DEPTH), .LINE_W(LINE_W), .ID_W(ID_W), .SEQ_W(SEQ_W)) queue_i (
      .clk, .rst_n,
      .push(q_push), .push_line(req_line), .push_id(req_src), .push_seq(req_seq),
      .pop(q_pop), .probe_line(req_line), .probe_hit(q_hit),
      .head_line, .head_id(head_src), .head_seq,
      .empty(q_empty), .full(q_full)
   );

   l2fl_dispatch #(.LINE_W(LINE_W), .DATA_W(DATA_W), .ID_W(ID_W), .SEQ_W(SEQ_W)) disp_i (
      .req_valid, .req_ready, .req_line, .req_src, .req_seq,
      .req_state, .req_data, .req_mask,
      .q_empty, .q_full, .q_hit,
      .head_line, .head_src, .head_seq, .head_state, .head_data, .head_mask,
      .q_push, .q_pop,
      .ack_valid, .ack_ready, .ack_dst, .ack_seq,
      .dir_valid, .dir_ready, .dir_line, .dir_src, .dir_seq, .dir_data, .dir_mask,
      .inv_en, .inv_idx
   );

   assign dir_dirty = dir_valid;

   assert_one_channel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(ack_valid && dir_valid));

   assert_stall_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      q_push |-> (!ack_valid && !dir_valid));

endmodule

// File: tb/l2fl_flush_top_tb_top.sv
module l2fl_flush_top_tb_top;

   localparam int LINES = 8, DATA_W = 64, ID_W = 4, SEQ_W = 8, QD = 4;
   localparam int LINE_W = 3, MASK_W = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              upd_en = 0;
   logic [LINE_W-1:0] upd_line = 0;
   logic [2:0]        upd_state = 0;
   logic [DATA_W-1:0] upd_data = 0;
   logic [MASK_W-1:0] upd_mask = 0;
   logic              req_valid = 0, ack_ready = 0, dir_ready = 0;
   logic [LINE_W-1:0] req_line = 0;
   logic [ID_W-1:0]   req_src = 0;
   logic [SEQ_W-1:0]  req_seq = 0;
   logic              req_ready, ack_valid, dir_valid, dir_dirty;
   logic [ID_W-1:0]   ack_dst, dir_src;
   logic [SEQ_W-1:0]  ack_seq, dir_seq;
   logic [LINE_W-1:0] dir_line;
   logic [DATA_W-1:0] dir_data;
   logic [MASK_W-1:0] dir_mask;

   l2fl_flush_top #(.LINES(LINES), .DATA_W(DATA_W), .ID_W(ID_W), .SEQ_W(SEQ_W), .Q_DEPTH(QD)) dut_i (
      .clk, .rst_n, .upd_en, .upd_line, .upd_state, .upd_data, .upd_mask,
      .req_valid, .req_ready, .req_line, .req_src, .req_seq,
      .ack_valid, .ack_ready, .ack_dst, .ack_seq,
      .dir_valid, .dir_ready, .dir_line, .dir_src, .dir_seq, .dir_data, .dir_mask, .dir_dirty
   );

   int checks = 0, errors = 0;

   // reference model
   int                m_st   [LINES];
   logic [DATA_W-1:0] m_data [LINES];
   logic [MASK_W-1:0] m_mask [LINES];
   int q_line[$], q_src[$], q_seq[$];

   function automatic bit holds(int s);
      return !(s == 0 || s == 1 || s == 2);
   endfunction

   task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic step(input bit uv, input int ul, input int us, input logic [63:0] ud,
                       input logic [7:0] um, input bit rv, input int rl, input int rs,
                       input int rq, input bit ar, input bit dr, input string force_tag);
      bit replay, hit, e_ack, e_dir, e_rdy, push, pop, fire, inv;
      int sl, ss, sq;
      string tg;
      @(negedge clk);
      upd_en = uv; upd_line = LINE_W'(ul); upd_state = 3'(us); upd_data = ud; upd_mask = um;
      req_valid = rv; req_line = LINE_W'(rl); req_src = ID_W'(rs); req_seq = SEQ_W'(rq);
      ack_ready = ar; dir_ready = dr;
      #1;
      replay = (q_line.size() > 0) && !holds(m_st[q_line[0]]);
      hit = 0;
      foreach (q_line[i]) if (q_line[i] == rl) hit = 1;
      e_ack = 0; e_dir = 0; e_rdy = 0; push = 0; pop = 0; fire = 0; inv = 0;
      sl = rl; ss = rs; sq = rq; tg = "R3";
      if (replay) begin
         sl = q_line[0]; ss = q_src[0]; sq = q_seq[0]; tg = "R7";
      end
      if (replay || (rv && !holds(m_st[rl]) && !hit)) begin
         if (m_st[sl] == 0) begin e_ack = 1; fire = ar; if (!replay) tg = "R3"; end
         else begin e_dir = 1; fire = dr; if (!replay) tg = "R4"; end
         if (!fire) tg = "R6";
         pop = replay && fire;
         e_rdy = !replay && fire;
      end else if (rv) begin
         e_rdy = q_line.size() < QD;
         push = e_rdy;
         tg = !e_rdy ? "R9" : (!holds(m_st[rl]) ? "R8" : "R2");
      end
      if (force_tag != "") tg = force_tag;
      check(ack_valid == e_ack, tg, "ack_valid", 64'(ack_valid), 64'(e_ack));
      check(dir_valid == e_dir, tg, "dir_valid", 64'(dir_valid), 64'(e_dir));
      if (rv) check(req_ready == e_rdy, tg, "req_ready", 64'(req_ready), 64'(e_rdy));
      if (e_ack && ack_valid) begin
         check(ack_dst == ID_W'(ss), tg, "ack_dst", 64'(ack_dst), 64'(ss));
         check(ack_seq == SEQ_W'(sq), tg, "ack_seq", 64'(ack_seq), 64'(sq));
      end
      if (e_dir && dir_valid) begin
         check(dir_line == LINE_W'(sl), tg, "dir_line", 64'(dir_line), 64'(sl));
         check(dir_src == ID_W'(ss), tg, "dir_src", 64'(dir_src), 64'(ss));
         check(dir_seq == SEQ_W'(sq), tg, "dir_seq", 64'(dir_seq), 64'(sq));
         check(dir_data == m_data[sl], tg, "dir_data", dir_data, m_data[sl]);
         check(dir_mask == m_mask[sl], tg, "dir_mask", 64'(dir_mask), 64'(m_mask[sl]));
         check(dir_dirty == 1'b1, tg, "dir_dirty", 64'(dir_dirty), 64'd1);
      end
      inv = e_dir && fire;
      if (uv && !(inv && ul == sl)) begin
         m_st[ul] = us; m_data[ul] = ud; m_mask[ul] = um;
      end
      if (inv) begin m_st[sl] = 0; m_mask[sl] = '0; end
      if (pop) begin void'(q_line.pop_front()); void'(q_src.pop_front()); void'(q_seq.pop_front()); end
      if (push) begin q_line.push_back(rl); q_src.push_back(rs); q_seq.push_back(rq); end
   endtask

   task automatic upd(int l, int s, logic [63:0] d, logic [7:0] m);
      step(1, l, s, d, m, 0, 0, 0, 0, 1, 1, "R2");
   endtask

   task automatic flush(int l, int s, int q, bit ar, bit dr, string tag);
      step(0, 0, 0, 0, 0, 1, l, s, q, ar, dr, tag);
   endtask

   initial begin : watchdog
      #1000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      for (int i = 0; i < LINES; i++) begin m_st[i] = 0; m_data[i] = '0; m_mask[i] = '0; end
      repeat (3) @(negedge clk);
      #1;
      check(ack_valid == 0 && dir_valid == 0, "R1", "outputs in reset", 64'({ack_valid, dir_valid}), 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: every line invalid after reset
      for (int l = 0; l < LINES; l++) flush(l, l, 8'h10 + l, 1, 1, "R1");
      // R4/R6/R5: valid line, directory stalls then accepts, then re-flush acks
      upd(2, 1, 64'hDEAD_BEEF_0123_4567, 8'hA5);
      flush(2, 3, 8'h21, 1, 0, "R6");
      flush(2, 3, 8'h21, 0, 1, "R4");
      flush(2, 4, 8'h22, 1, 1, "R5");
      // R2/R7: atomic-pending line queues, replay in order
      upd(5, 3, 64'h1111, 8'h0F);
      flush(5, 1, 8'h31, 1, 1, "R2");
      flush(5, 2, 8'h32, 1, 1, "R2");
      flush(1, 6, 8'h33, 1, 1, "R3");
      upd(5, 2, 64'h2222_3333, 8'hF0);
      step(0, 0, 0, 0, 0, 1, 0, 7, 8'h34, 1, 1, "R7");
      step(0, 0, 0, 0, 0, 1, 0, 7, 8'h34, 1, 1, "R7");
      flush(0, 7, 8'h34, 1, 1, "R3");
      // R9: full queue
      upd(6, 4, 64'h0, 8'h0);
      for (int k = 0; k < QD; k++) flush(6, k, 8'h40 + k, 1, 1, "R2");
      flush(6, 9, 8'h4F, 1, 1, "R9");
      upd(6, 0, 64'h0, 8'h0);
      for (int k = 0; k < QD; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R7");
      // R8: stable line matching a queued entry
      upd(4, 3, 64'h44, 8'h01);
      upd(7, 5, 64'h77, 8'h02);
      flush(4, 1, 8'h51, 1, 1, "R2");
      flush(7, 2, 8'h52, 1, 1, "R2");
      upd(7, 1, 64'h7777, 8'h03);
      flush(7, 3, 8'h53, 1, 1, "R8");
      upd(4, 0, 64'h0, 8'h0);
      for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R7");
      // R10: update collides with accepted directory message
      upd(3, 2, 64'hCAFE, 8'hFF);
      step(1, 3, 1, 64'hBEEF, 8'h11, 1, 3, 5, 8'h61, 1, 1, "R10");
      flush(3, 5, 8'h62, 1, 1, "R10");
      // mixed traffic
      for (int n = 0; n < 4000; n++) begin
         step(($urandom % 4) == 0, $urandom % LINES, $urandom % 8,
              {$urandom, $urandom}, 8'($urandom),
              ($urandom % 3) != 0, $urandom % LINES, $urandom % 16, $urandom % 256,
              ($urandom % 4) != 0, ($urandom % 4) != 0, "");
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule